// File: doc/BRIEF.md
# External Master Bus Slave Responder

This block lets an external bus master reach on-chip resources once it holds the shared external bus. When the master owns the bus and pulses the transfer start strobe, the responder compares the address against an internal window. The window is a base and mask pair captured while reset is held. A matching access is passed to a simple internal request port. The responder keeps the bus cycle open until the internal side replies or a programmable timeout runs out. It then ends the access with exactly one one-clock termination: a normal acknowledge, an error acknowledge or a retry.

A second, independent section serves the case where the chip itself is the bus master. It decodes the three termination inputs with a fixed priority. Error beats retry, and retry beats acknowledge. An error input still present on the clock right after a recognised error is treated as a slow release and ignored.

Top module: `xm_slave_resp`

## Requirements
- R1: While reset is asserted and on the first clock after it, the three termination outputs, the internal request valid and the decoder outputs are all low.
- R2: An access starts only when `ext_own` and `ext_start` are both high in an idle clock and `(ext_addr & mask) == (base & mask)`. Otherwise no internal request and no termination follow.
- R3: From the clock after the start, `int_req_valid` is high with `int_addr`, `int_wdata` and `int_wr` equal to the sampled access. These fields stay unchanged until `int_req_ready` is seen or the timeout ends the access.
- R4: A reply with `int_req_ready` high and both flags low gives `ext_ack_o` high for one clock, in the clock after the reply. For a read, `ext_rdata` carries the replied data during that clock.
- R5: A reply with `int_err` high gives `ext_err_o` for one clock, whatever `int_retry` shows.
- R6: A reply with `int_retry` high and `int_err` low gives `ext_rty_o` for one clock.
- R7: With a captured timeout T (T >= 1), an access that gets no reply within T request clocks ends with `ext_err_o` in the next clock. The request is then withdrawn.
- R8: At most one termination output is high in any clock, and all three are low in the clock after any termination.
- R9: A start strobe that arrives while an access is in progress (request or termination clock) is ignored.
- R10: Base, mask and timeout are taken only while reset is high. Later changes on `cfg_base`, `cfg_mask` and `cfg_tout` have no effect.
- R11: While `own_cyc` is high, the decoder raises `own_fin_err` if `own_tea` is high, else `own_fin_rty` if `own_rty` is high, else `own_fin_ok` if `own_ta` is high. With `own_cyc` low, all three decoder outputs are low.
- R12: On the clock right after `own_fin_err` was high, `own_tea` is ignored. The decoder then acts as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Window base, captured during reset |
| cfg_mask | input | AW | Window mask, captured during reset |
| cfg_tout | input | TW | Request timeout in clocks, captured during reset |
| ext_own | input | 1 | External master holds the bus |
| ext_start | input | 1 | Transfer start strobe |
| ext_addr | input | AW | Access address |
| ext_wdata | input | DW | Write data |
| ext_wr | input | 1 | 1 = write, 0 = read |
| ext_rdata | output | DW | Read data during acknowledge clock |
| ext_ack_o | output | 1 | Normal termination |
| ext_err_o | output | 1 | Error termination |
| ext_rty_o | output | 1 | Retry termination |
| int_req_valid | output | 1 | Internal request pending |
| int_addr | output | AW | Internal request address |
| int_wdata | output | DW | Internal request write data |
| int_wr | output | 1 | Internal request direction |
| int_req_ready | input | 1 | Internal side replies |
| int_rdata | input | DW | Reply data |
| int_err | input | 1 | Reply flags an error |
| int_retry | input | 1 | Reply asks for a retry |
| own_cyc | input | 1 | Chip-mastered cycle outstanding |
| own_ta | input | 1 | Acknowledge input |
| own_tea | input | 1 | Error acknowledge input |
| own_rty | input | 1 | Retry input |
| own_fin_ok | output | 1 | Decoded normal termination |
| own_fin_err | output | 1 | Decoded error termination |
| own_fin_rty | output | 1 | Decoded retry termination |

## Verification
Every address of an 8-bit space is presented with a rotating mix of bus ownership, reply delay, reply flags and direction. This separates window hits from misses, ownership gating, each reply kind and replies that land just before or just after the timeout. The expected clock of each termination is checked, so off-by-one errors in the timeout or reply path show up. A start held during a busy access shows whether a second request leaks through. The decoder is swept over all sixteen input combinations and then fed a lingering error input, which tells the priority order apart from the release blanking.

// File: rtl/xm_slave_pkg.sv
package xm_slave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_TERM = 2'd2
    } xm_state_e;

    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_ACK  = 2'd1,
        TERM_ERR  = 2'd2,
        TERM_RTY  = 2'd3
    } term_e;

    typedef struct packed {
        logic err;
        logic rty;
        logic ack;
    } term_flags_t;

    // Fixed termination priority: error, then retry, then acknowledge.
    function automatic term_e pick_term(input term_flags_t f);
        if (f.err)      return TERM_ERR;
        else if (f.rty) return TERM_RTY;
        else if (f.ack) return TERM_ACK;
        else            return TERM_NONE;
    endfunction

endpackage

// File: rtl/xm_win_cfg.sv
module xm_win_cfg #(
    parameter int AW = 32,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_mask,
    input  logic [TW-1:0] cfg_tout,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [TW-1:0] tout_q
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] mask_q;

    // Configuration is followed only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= cfg_base;
            mask_q <= cfg_mask;
            tout_q <= cfg_tout;
        end
    end

    assign hit = ((addr ^ base_q) & mask_q) == '0;

endmodule

// File: rtl/xm_resp_fsm.sv
module xm_resp_fsm
    import xm_slave_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_ok,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic [TW-1:0] tout,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic          req_wr,
    input  logic          req_ready,
    input  logic [DW-1:0] rsp_rdata,
    input  logic          rsp_err,
    input  logic          rsp_retry,
    output term_e         term_kind,
    output logic [DW-1:0] rdata
);
    localparam int CW = TW + 1;

    xm_state_e     state_q;
    logic [TW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;
    logic          tout_hit;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;
    logic [DW-1:0] rdata_q;
    term_e         kind_q;
    term_flags_t   rsp_flags;

    assign cnt_next  = {1'b0, cnt_q} + CW'(1);
    assign tout_hit  = cnt_next >= {1'b0, tout};
    assign rsp_flags = '{err: rsp_err, rty: rsp_retry, ack: 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
            kind_q  <= TERM_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    kind_q <= TERM_NONE;
                    if (start_ok) begin
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        wr_q    <= wr;
                        cnt_q   <= '0;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        kind_q  <= pick_term(rsp_flags);
                        rdata_q <= rsp_rdata;
                        state_q <= ST_TERM;
                    end else if (tout_hit) begin
                        kind_q  <= TERM_ERR;
                        rdata_q <= '0;
                        state_q <= ST_TERM;
                    end else begin
                        cnt_q <= cnt_next[TW-1:0];
                    end
                end
                ST_TERM: begin
                    kind_q  <= TERM_NONE;
                    state_q <= ST_IDLE;
                end
                default: begin
                    kind_q  <= TERM_NONE;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_valid = (state_q == ST_REQ);
    assign req_addr  = addr_q;
    assign req_wdata = wdata_q;
    assign req_wr    = wr_q;
    assign term_kind = (state_q == ST_TERM) ? kind_q : TERM_NONE;
    assign rdata     = (state_q == ST_TERM && kind_q == TERM_ACK && !wr_q) ? rdata_q : '0;

endmodule

// File: rtl/xm_term_dec.sv
module xm_term_dec
    import xm_slave_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic ta,
    input  logic tea,
    input  logic rty,
    output logic fin_ok,
    output logic fin_err,
    output logic fin_rty
);
    logic        blank_q;
    term_flags_t seen;
    term_e       kind;

    // A lingering error level right after a recognised error is a slow release.
    assign seen = '{err: tea && !blank_q, rty: rty, ack: ta};
    assign kind = cyc ? pick_term(seen) : TERM_NONE;

    assign fin_ok  = (kind == TERM_ACK);
    assign fin_err = (kind == TERM_ERR);
    assign fin_rty = (kind == TERM_RTY);

    always_ff @(posedge clk) begin
        if (rst) blank_q <= 1'b0;
        else     blank_q <= fin_err;
    end

endmodule

// File: rtl/xm_slave_resp.sv
module xm_slave_resp
    import xm_slave_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_mask,
    input  logic [TW-1:0] cfg_tout,
    input  logic          ext_own,
    input  logic          ext_start,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_wdata,
    input  logic          ext_wr,
    output logic [DW-1:0] ext_rdata,
    output logic          ext_ack_o,
    output logic          ext_err_o,
    output logic          ext_rty_o,
    output logic          int_req_valid,
    output logic [AW-1:0] int_addr,
    output logic [DW-1:0] int_wdata,
    output logic          int_wr,
    input  logic          int_req_ready,
    input  logic [DW-1:0] int_rdata,
    input  logic          int_err,
    input  logic          int_retry,
    input  logic          own_cyc,
    input  logic          own_ta,
    input  logic          own_tea,
    input  logic          own_rty,
    output logic          own_fin_ok,
    output logic          own_fin_err,
    output logic          own_fin_rty
);
    logic          win_hit;
    logic [TW-1:0] tout_lat;
    logic          start_ok;
    term_e         term_kind;

    xm_win_cfg #(.AW(AW), .TW(TW)) u_win (
        .clk      (clk),
        .rst      (rst),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .cfg_tout (cfg_tout),
        .addr     (ext_addr),
        .hit      (win_hit),
        .tout_q   (tout_lat)
    );

    assign start_ok = ext_start && ext_own && win_hit;

    xm_resp_fsm #(.AW(AW), .DW(DW), .TW(TW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .addr      (ext_addr),
        .wdata     (ext_wdata),
        .wr        (ext_wr),
        .tout      (tout_lat),
        .req_valid (int_req_valid),
        .req_addr  (int_addr),
        .req_wdata (int_wdata),
        .req_wr    (int_wr),
        .req_ready (int_req_ready),
        .rsp_rdata (int_rdata),
        .rsp_err   (int_err),
        .rsp_retry (int_retry),
        .term_kind (term_kind),
        .rdata     (ext_rdata)
    );

    assign ext_ack_o = (term_kind == TERM_ACK);
    assign ext_err_o = (term_kind == TERM_ERR);
    assign ext_rty_o = (term_kind == TERM_RTY);

    xm_term_dec u_dec (
        .clk     (clk),
        .rst     (rst),
        .cyc     (own_cyc),
        .ta      (own_ta),
        .tea     (own_tea),
        .rty     (own_rty),
        .fin_ok  (own_fin_ok),
        .fin_err (own_fin_err),
        .fin_rty (own_fin_rty)
    );

endmodule

// File: rtl/xm_slave_resp_chk.sv
module xm_slave_resp_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_ack_o,
    input logic          ext_err_o,
    input logic          ext_rty_o,
    input logic          int_req_valid,
    input logic [AW-1:0] int_addr,
    input logic          int_req_ready,
    input logic          int_err,
    input logic          int_retry,
    input logic          own_cyc,
    input logic          own_ta,
    input logic          own_tea,
    input logic          own_rty,
    input logic          own_fin_ok,
    input logic          own_fin_err,
    input logic          own_fin_rty,
    input logic [TW-1:0] tout_q
);
    logic [TW:0] run_q;
    logic [TW:0] run_lim;
    logic        any_term;

    assign any_term = ext_ack_o || ext_err_o || ext_rty_o;
    assign run_lim  = (tout_q == '0) ? (TW+1)'(1) : {1'b0, tout_q};

    always_ff @(posedge clk) begin
        if (rst)                run_q <= '0;
        else if (int_req_valid) run_q <= run_q + (TW+1)'(1);
        else                    run_q <= '0;
    end

    // R8
    one_term_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_ack_o, ext_err_o, ext_rty_o}));

    // R8
    term_gap_chk: assert property (@(posedge clk) disable iff (rst)
        any_term |=> !any_term);

    // R4
    ack_src_chk: assert property (@(posedge clk) disable iff (rst)
        ext_ack_o |-> $past(int_req_valid && int_req_ready && !int_err && !int_retry));

    // R6
    rty_src_chk: assert property (@(posedge clk) disable iff (rst)
        ext_rty_o |-> $past(int_req_valid && int_req_ready && int_retry && !int_err));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req_valid && !int_req_ready) |=> ((int_req_valid && $stable(int_addr)) || ext_err_o));

    // R7
    tout_win_chk: assert property (@(posedge clk) disable iff (rst)
        int_req_valid |-> (run_q < run_lim));

    // R11
    dec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({own_fin_ok, own_fin_err, own_fin_rty}));

    // R11
    dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !own_cyc |-> !(own_fin_ok || own_fin_err || own_fin_rty));

    // R11
    dec_ok_chk: assert property (@(posedge clk) disable iff (rst)
        own_fin_ok |-> (own_ta && !own_rty));

    // R12
    dec_blank_chk: assert property (@(posedge clk) disable iff (rst)
        $past(own_fin_err && !rst) |-> !own_fin_err);

endmodule

bind xm_slave_resp xm_slave_resp_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ext_ack_o     (ext_ack_o),
    .ext_err_o     (ext_err_o),
    .ext_rty_o     (ext_rty_o),
    .int_req_valid (int_req_valid),
    .int_addr      (int_addr),
    .int_req_ready (int_req_ready),
    .int_err       (int_err),
    .int_retry     (int_retry),
    .own_cyc       (own_cyc),
    .own_ta        (own_ta),
    .own_tea       (own_tea),
    .own_rty       (own_rty),
    .own_fin_ok    (own_fin_ok),
    .own_fin_err   (own_fin_err),
    .own_fin_rty   (own_fin_rty),
    .tout_q        (tout_lat)
);

// File: tb/sim_xm_slave_resp.sv
module sim_xm_slave_resp;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int TW = 4;
    localparam int TO = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] cfg_base = 8'h40;
    logic [AW-1:0] cfg_mask = 8'hC0;
    logic [TW-1:0] cfg_tout = 4'(TO);
    logic ext_own = 0, ext_start = 0, ext_wr = 0;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] ext_wdata = '0;
    logic [DW-1:0] ext_rdata;
    logic ext_ack_o, ext_err_o, ext_rty_o;
    logic int_req_valid, int_wr;
    logic [AW-1:0] int_addr;
    logic [DW-1:0] int_wdata;
    logic int_req_ready = 0, int_err = 0, int_retry = 0;
    logic [DW-1:0] int_rdata = '0;
    logic own_cyc = 0, own_ta = 0, own_tea = 0, own_rty = 0;
    logic own_fin_ok, own_fin_err, own_fin_rty;

    int n_chk = 0;
    int n_bad = 0;
    int rsp_dly = 0;
    logic rsp_e = 0, rsp_r = 0;
    int rcnt = 0;

    always #2 clk = ~clk;

    xm_slave_resp #(.AW(AW), .DW(DW), .TW(TW)) u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Internal-side model: replies after rsp_dly request clocks.
    always @(negedge clk) begin
        if (int_req_valid) begin
            if (rcnt == rsp_dly) begin
                int_req_ready <= 1'b1;
                int_err       <= rsp_e;
                int_retry     <= rsp_r;
                int_rdata     <= int_addr ^ 8'h5A;
            end else begin
                int_req_ready <= 1'b0;
            end
            rcnt <= rcnt + 1;
        end else begin
            int_req_ready <= 1'b0;
            int_err       <= 1'b0;
            int_retry     <= 1'b0;
            rcnt          <= 0;
        end
    end

    function automatic int term_code();
        return ext_ack_o ? 1 : ext_err_o ? 2 : ext_rty_o ? 3 : 0;
    endfunction

    task automatic access(input logic [7:0] a, input logic own, input logic wr,
                          input int dly, input logic e, input logic r);
        logic hit;
        int exp_kind, kind, t_idx, n_term, req_bad, exp_idx;
        logic [7:0] rd;
        hit = own && ((a & 8'hC0) == 8'h40);
        if (!hit)           exp_kind = 0;
        else if (dly >= TO) exp_kind = 2;
        else if (e)         exp_kind = 2;
        else if (r)         exp_kind = 3;
        else                exp_kind = 1;
        exp_idx = (dly >= TO) ? TO : dly + 1;
        @(negedge clk);
        rsp_dly = dly; rsp_e = e; rsp_r = r;
        ext_start = 1; ext_own = own; ext_addr = a; ext_wr = wr; ext_wdata = ~a;
        @(negedge clk);
        ext_start = 0; ext_addr = 8'h00; ext_wdata = 8'h00;
        kind = 0; t_idx = -1; n_term = 0; req_bad = 0; rd = 0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            if (int_req_valid && (int_addr != a || int_wr != wr || int_wdata != ~a))
                req_bad++;
            if (!hit && int_req_valid) req_bad++;
            if (term_code() != 0) begin
                n_term++;
                kind = term_code();
                t_idx = k;
                rd = ext_rdata;
            end
        end
        if (exp_kind == 0) check("R2 R10 miss gives no termination", kind, 0);
        else if (dly >= TO) check("R7 timeout error", kind, exp_kind);
        else if (exp_kind == 2) check("R5 error reply", kind, exp_kind);
        else if (exp_kind == 3) check("R6 retry reply", kind, exp_kind);
        else check("R4 ack reply", kind, exp_kind);
        check("R3 request fields", req_bad, 0);
        if (exp_kind != 0) begin
            check("R8 single termination clock", n_term, 1);
            check("R4 R7 termination timing", t_idx, exp_idx);
            if (exp_kind == 1 && !wr) check("R4 read data", int'(rd), int'(a ^ 8'h5A));
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset ack", ext_ack_o, 0);
        check("R1 reset err", ext_err_o, 0);
        check("R1 reset rty", ext_rty_o, 0);
        check("R1 reset req", int_req_valid, 0);
        rst = 0;
        // R10: disturb configuration pins after reset; window must not follow.
        cfg_base = 8'h00; cfg_mask = 8'h00; cfg_tout = 4'd15;
        @(negedge clk);
        check("R1 after reset term", term_code(), 0);
        check("R1 after reset dec", int'({own_fin_ok, own_fin_err, own_fin_rty}), 0);

        for (int a = 0; a < 256; a++)
            access(8'(a), (a % 5) != 4, a[0], a % 6, (a % 7) == 1, (a % 3) == 2);

        // Boundaries around the timeout
        access(8'h50, 1, 0, TO - 1, 0, 0);
        access(8'h51, 1, 0, TO, 0, 0);
        access(8'h52, 1, 0, 0, 1, 1);

        // R9: start held through a busy access with another in-window address
        begin
            int req_bad, n_term, kind;
            req_bad = 0; n_term = 0; kind = 0;
            @(negedge clk);
            rsp_dly = 2; rsp_e = 0; rsp_r = 0;
            ext_start = 1; ext_own = 1; ext_addr = 8'h41; ext_wr = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (k < 4) ext_addr = 8'h62; else ext_start = 0;
                if (int_req_valid && int_addr != 8'h41) req_bad++;
                if (term_code() != 0) begin n_term++; kind = term_code(); end
                if (k == 3) ext_start = 0;
            end
            ext_start = 0;
            check("R9 busy start ignored addr", req_bad, 0);
            check("R9 busy start one termination", n_term, 1);
            check("R9 busy access acked", kind, 1);
            repeat (4) @(negedge clk);
            check("R9 no late second request", int_req_valid, 0);
        end

        // R11: exhaustive decoder sweep, each combination after a clean clock
        for (int v = 0; v < 16; v++) begin
            int exp;
            @(negedge clk);
            own_cyc = 0; own_ta = 0; own_tea = 0; own_rty = 0;
            @(negedge clk);
            own_cyc = v[3]; own_ta = v[2]; own_tea = v[1]; own_rty = v[0];
            #1;
            if (!v[3])     exp = 0;
            else if (v[1]) exp = 2;
            else if (v[0]) exp = 3;
            else if (v[2]) exp = 1;
            else           exp = 0;
            check("R11 decode priority",
                  own_fin_ok ? 1 : own_fin_err ? 2 : own_fin_rty ? 3 : 0, exp);
            check("R11 decode one-hot",
                  int'(own_fin_ok) + int'(own_fin_err) + int'(own_fin_rty), (exp != 0) ? 1 : 0);
        end

        // R12: lingering error level
        @(negedge clk);
        own_cyc = 0; own_ta = 0; own_tea = 0; own_rty = 0;
        @(negedge clk);
        own_cyc = 1; own_tea = 1;
        #1 check("R12 first error seen", own_fin_err, 1);
        @(negedge clk);
        own_ta = 1;
        #1 check("R12 lingering error ignored", own_fin_err, 0);
        check("R12 ack seen under blank", own_fin_ok, 1);
        @(negedge clk);
        own_ta = 0;
        #1 check("R12 error seen again after blank", own_fin_err, 1);
        @(negedge clk);
        own_cyc = 0; own_tea = 0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule